// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard control unit of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. It looks at the operation codes now held in the decode, execute and memory pipeline registers, at the source register identifiers of the decode instruction, at the memory-result destination of the execute instruction, and at the branch outcome the execute stage computes. From these it produces a hold (stall) and a flush-to-no-op (bubble) control for each stage register, together with a misprediction flag.

Three hazard policies are covered. First, a load followed at once by a consumer of its result costs one stall cycle. Second, a subroutine return blocks fetch for three cycles, until its target has been read from data memory. Third, a conditional jump is predicted taken, and a wrong guess, found in execute, squashes the two younger instructions. When these policies overlap, a fixed precedence decides the outcome. The datapath, the forwarding paths and the pipeline registers themselves sit outside this block. The pipeline registers apply the stall and bubble vectors at the next clock edge.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: With no hazard present (for example no-op code 0x1 in every stage and register identifiers 0xF), every stall and bubble bit and the misprediction flag are 0. In both vectors, bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 memory and bit 4 writeback.
- R2: A load (code 0x5) or pop (code 0xB) in execute whose memory destination equals decode source A or source B gives stall = 5'b00011 and bubble = 5'b00100.
- R3: No load/use hazard is raised when the identifiers differ, when the matching identifier is 0xF (no register), or when the execute code is not a load or a pop.
- R4: A return (code 0x9) in decode, execute or memory, with no other hazard, gives stall = 5'b00001 and bubble = 5'b00010. A return walking from decode to writeback therefore holds fetch for exactly 3 cycles.
- R5: A conditional jump (code 0x7) in execute with the taken input at 0 raises the misprediction flag and gives bubble = 5'b00110 and stall = 5'b00000, so fetch advances.
- R6: A jump in execute with taken at 1 raises no misprediction. The taken input has no effect when the execute code is not a jump.
- R7: A misprediction together with a return in decode produces the misprediction response of R5. The return does not stall fetch.
- R8: A load/use hazard together with a return in decode, execute or memory gives stall = 5'b00011 and bubble = 5'b00100. Holding decode wins over bubbling it.
- R9: No stage has stall and bubble set at the same time. The memory and writeback bits of both vectors are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_dec_i | input | 4 | Operation code in the decode register |
| op_exe_i | input | 4 | Operation code in the execute register |
| op_mem_i | input | 4 | Operation code in the memory register |
| src_a_dec_i | input | 4 | Decode source register A (0xF = none) |
| src_b_dec_i | input | 4 | Decode source register B (0xF = none) |
| dst_ld_exe_i | input | 4 | Execute destination written from memory (0xF = none) |
| taken_exe_i | input | 1 | Branch condition evaluated in execute |
| stall_o | output | 5 | Per-stage hold, bit 0 fetch to bit 4 writeback |
| bubble_o | output | 5 | Per-stage flush to no-op, same bit order |
| mispredict_o | output | 1 | Jump in execute was predicted wrongly |

## Verification
The hardest situations to create are the overlaps: a return in decode while a not-taken jump sits in execute, and a return that itself reads the register a load in execute is about to produce. In a running pipeline these arise only from particular instruction orders. Because the block is combinational, the stimulus table places each overlap directly into the stage codes. A short directed walk then steps one return from decode through writeback and counts the fetch-hold cycles.

// File: rtl/hzc_pkg.sv
// Shared encodings for the hazard controller.
// Assumes 4-bit operation codes and 4-bit register identifiers.
package hzc_pkg;
    localparam int OP_W     = 4;
    localparam int REG_W    = 4;
    localparam int STAGES   = 5;
    localparam int ST_FETCH = 0;
    localparam int ST_DEC   = 1;
    localparam int ST_EXE   = 2;
    localparam int ST_MEM   = 3;
    localparam int ST_WB    = 4;

    localparam logic [OP_W-1:0]  OP_NOP   = 4'h1;
    localparam logic [OP_W-1:0]  OP_ALU   = 4'h2;
    localparam logic [OP_W-1:0]  OP_LOAD  = 4'h5;
    localparam logic [OP_W-1:0]  OP_JCOND = 4'h7;
    localparam logic [OP_W-1:0]  OP_RET   = 4'h9;
    localparam logic [OP_W-1:0]  OP_POP   = 4'hB;
    localparam logic [REG_W-1:0] REG_NONE = 4'hF;
endpackage

// File: rtl/hzc_loaduse_det.sv
// Load/use detector: flags a load or pop in execute whose memory result
// feeds a source of the decode instruction. Assumes REG_NONE never matches.
module hzc_loaduse_det
    import hzc_pkg::*;
(
    input  logic [OP_W-1:0]  op_exe_i,
    input  logic [REG_W-1:0] dst_ld_exe_i,
    input  logic [REG_W-1:0] src_a_dec_i,
    input  logic [REG_W-1:0] src_b_dec_i,
    output logic             hit_o
);
    logic is_load;
    logic dst_valid;

    // Decide whether the execute instruction reads memory into a register.
    always_comb begin
        is_load   = (op_exe_i == OP_LOAD) || (op_exe_i == OP_POP);
        dst_valid = (dst_ld_exe_i != REG_NONE);
        hit_o     = is_load && dst_valid &&
                    ((dst_ld_exe_i == src_a_dec_i) || (dst_ld_exe_i == src_b_dec_i));
    end
endmodule

// File: rtl/hzc_ret_det.sv
// Return detector: reports a return still ahead of its target read,
// i.e. in decode, execute or memory.
module hzc_ret_det
    import hzc_pkg::*;
(
    input  logic [OP_W-1:0] op_dec_i,
    input  logic [OP_W-1:0] op_exe_i,
    input  logic [OP_W-1:0] op_mem_i,
    output logic            pending_o
);
    // A return anywhere before writeback blocks fetch.
    always_comb begin
        pending_o = (op_dec_i == OP_RET) || (op_exe_i == OP_RET) ||
                    (op_mem_i == OP_RET);
    end
endmodule

// File: rtl/hzc_branch_chk.sv
// Branch checker: under predict-taken, a conditional jump resolved
// not taken in execute is a misprediction.
module hzc_branch_chk
    import hzc_pkg::*;
(
    input  logic [OP_W-1:0] op_exe_i,
    input  logic            taken_exe_i,
    output logic            miss_o
);
    // Compare the resolved outcome with the static taken guess.
    always_comb begin
        miss_o = (op_exe_i == OP_JCOND) && !taken_exe_i;
    end
endmodule

// File: rtl/hzc_arbiter.sv
// Arbiter: turns the three hazard flags into per-stage stall/bubble
// vectors. Precedence: misprediction, then load/use, then return.
module hzc_arbiter
    import hzc_pkg::*;
(
    input  logic               miss_i,
    input  logic               loaduse_i,
    input  logic               ret_i,
    output logic [STAGES-1:0]  stall_o,
    output logic [STAGES-1:0]  bubble_o
);
    logic lu_eff;

    // Build the control vectors from the winning policy.
    always_comb begin
        lu_eff   = loaduse_i && !miss_i;
        stall_o  = '0;
        bubble_o = '0;
        stall_o[ST_FETCH] = (lu_eff || ret_i) && !miss_i;
        stall_o[ST_DEC]   = lu_eff;
        bubble_o[ST_DEC]  = miss_i || (ret_i && !lu_eff);
        bubble_o[ST_EXE]  = miss_i || lu_eff;
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
// Hazard controller top: combines load/use, return and misprediction
// detection and arbitrates them into per-stage controls. Purely
// combinational; the pipeline registers apply the outputs at their edge.
module pipe_hazard_ctrl
    import hzc_pkg::*;
(
    input  logic [3:0] op_dec_i,
    input  logic [3:0] op_exe_i,
    input  logic [3:0] op_mem_i,
    input  logic [3:0] src_a_dec_i,
    input  logic [3:0] src_b_dec_i,
    input  logic [3:0] dst_ld_exe_i,
    input  logic       taken_exe_i,
    output logic [4:0] stall_o,
    output logic [4:0] bubble_o,
    output logic       mispredict_o
);
    logic lu_hit;
    logic ret_pend;
    logic br_miss;

    hzc_loaduse_det i_lu (
        .op_exe_i(op_exe_i), .dst_ld_exe_i(dst_ld_exe_i),
        .src_a_dec_i(src_a_dec_i), .src_b_dec_i(src_b_dec_i), .hit_o(lu_hit)
    );
    hzc_ret_det i_ret (
        .op_dec_i(op_dec_i), .op_exe_i(op_exe_i), .op_mem_i(op_mem_i),
        .pending_o(ret_pend)
    );
    hzc_branch_chk i_br (
        .op_exe_i(op_exe_i), .taken_exe_i(taken_exe_i), .miss_o(br_miss)
    );
    hzc_arbiter i_arb (
        .miss_i(br_miss), .loaduse_i(lu_hit), .ret_i(ret_pend),
        .stall_o(stall_o), .bubble_o(bubble_o)
    );

    // Export the branch outcome for the fetch redirect.
    always_comb mispredict_o = br_miss;

    // Invariants guarding the arbitration outputs.
    always_comb begin
        p_exclusive_r9: assert ((stall_o & bubble_o) == 5'b0)
            else $error("stall and bubble both set");
        p_late_idle_r9: assert (stall_o[4:3] == 2'b0 && bubble_o[4:3] == 2'b0)
            else $error("memory/writeback control set");
        p_loaduse_r2: assert (!lu_hit || (stall_o[1] && bubble_o[2] && stall_o[0]))
            else $error("load/use not held");
        p_ret_r4: assert (!(ret_pend && !lu_hit && !br_miss) ||
                          (stall_o[0] && bubble_o[1]))
            else $error("return not held");
        p_miss_r5: assert (!br_miss || (bubble_o[1] && bubble_o[2] && !stall_o[0]))
            else $error("misprediction not squashed");
    end
endmodule

// File: tb/test_pipe_hazard_ctrl.sv
module test_pipe_hazard_ctrl;
    logic       clk = 1'b0;
    logic [3:0] op_d, op_e, op_m, sa, sb, dst;
    logic       tk;
    logic [4:0] stall, bubble;
    logic       mp;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    pipe_hazard_ctrl i_pipe_hazard_ctrl (
        .op_dec_i(op_d), .op_exe_i(op_e), .op_mem_i(op_m),
        .src_a_dec_i(sa), .src_b_dec_i(sb), .dst_ld_exe_i(dst),
        .taken_exe_i(tk), .stall_o(stall), .bubble_o(bubble), .mispredict_o(mp)
    );

    // {req, op_d, op_e, op_m, srcA, srcB, dst, taken, stall, bubble, mp}
    localparam int NV = 16;
    localparam logic [39:0] VEC [NV] = '{
        {4'd1, 4'h1,4'h1,4'h1, 4'hF,4'hF,4'hF, 1'b0, 5'b00000,5'b00000,1'b0}, // R1 idle
        {4'd2, 4'h2,4'h5,4'h1, 4'h3,4'hF,4'h3, 1'b0, 5'b00011,5'b00100,1'b0}, // R2 load, srcA
        {4'd2, 4'h2,4'hB,4'h1, 4'h1,4'h4,4'h4, 1'b0, 5'b00011,5'b00100,1'b0}, // R2 pop, srcB
        {4'd3, 4'h2,4'h5,4'h1, 4'h5,4'h6,4'h3, 1'b0, 5'b00000,5'b00000,1'b0}, // R3 differ
        {4'd3, 4'h2,4'h5,4'h1, 4'hF,4'hF,4'hF, 1'b0, 5'b00000,5'b00000,1'b0}, // R3 none id
        {4'd3, 4'h2,4'h2,4'h1, 4'h3,4'h3,4'h3, 1'b0, 5'b00000,5'b00000,1'b0}, // R3 non-load
        {4'd4, 4'h9,4'h1,4'h1, 4'h4,4'hF,4'hF, 1'b0, 5'b00001,5'b00010,1'b0}, // R4 ret dec
        {4'd4, 4'h1,4'h9,4'h1, 4'hF,4'hF,4'hF, 1'b0, 5'b00001,5'b00010,1'b0}, // R4 ret exe
        {4'd4, 4'h1,4'h1,4'h9, 4'hF,4'hF,4'hF, 1'b0, 5'b00001,5'b00010,1'b0}, // R4 ret mem
        {4'd5, 4'h2,4'h7,4'h1, 4'h1,4'h2,4'hF, 1'b0, 5'b00000,5'b00110,1'b1}, // R5 miss
        {4'd6, 4'h2,4'h7,4'h1, 4'h1,4'h2,4'hF, 1'b1, 5'b00000,5'b00000,1'b0}, // R6 taken
        {4'd6, 4'h2,4'h2,4'h1, 4'h1,4'h2,4'hF, 1'b0, 5'b00000,5'b00000,1'b0}, // R6 alu, nt
        {4'd6, 4'h2,4'h2,4'h1, 4'h1,4'h2,4'hF, 1'b1, 5'b00000,5'b00000,1'b0}, // R6 alu, t
        {4'd7, 4'h9,4'h7,4'h1, 4'h4,4'hF,4'hF, 1'b0, 5'b00000,5'b00110,1'b1}, // R7 miss+ret
        {4'd8, 4'h9,4'h5,4'h1, 4'h4,4'hF,4'h4, 1'b0, 5'b00011,5'b00100,1'b0}, // R8 ret dec
        {4'd8, 4'h2,4'hB,4'h9, 4'h6,4'hF,4'h6, 1'b0, 5'b00011,5'b00100,1'b0}  // R8 ret mem
    };

    task automatic check(input string req, input logic [4:0] es, input logic [4:0] eb,
                         input logic em);
        checks++;
        if (stall !== es || bubble !== eb || mp !== em) begin
            errors++;
            $display("FAIL %s: stall=%b bubble=%b mp=%b expected stall=%b bubble=%b mp=%b",
                     req, stall, bubble, mp, es, eb, em);
        end
        // R9: exclusivity checked on every vector
        checks++;
        if ((stall & bubble) != 5'b0 || stall[4:3] != 2'b0 || bubble[4:3] != 2'b0) begin
            errors++;
            $display("FAIL R9: stall=%b bubble=%b expected disjoint, upper bits 0",
                     stall, bubble);
        end
    endtask

    task automatic drive(input logic [3:0] d, input logic [3:0] e, input logic [3:0] m,
                         input logic [3:0] a, input logic [3:0] b, input logic [3:0] t,
                         input logic k);
        @(negedge clk);
        op_d = d; op_e = e; op_m = m; sa = a; sb = b; dst = t; tk = k;
        #1;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int fetch_holds;
        op_d = 4'h1; op_e = 4'h1; op_m = 4'h1; sa = 4'hF; sb = 4'hF; dst = 4'hF; tk = 1'b0;
        // R1: quiet state after start-up
        drive(4'h1, 4'h1, 4'h1, 4'hF, 4'hF, 4'hF, 1'b0);
        check("R1", 5'b0, 5'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][35:32], VEC[i][31:28], VEC[i][27:24], VEC[i][23:20],
                  VEC[i][19:16], VEC[i][15:12], VEC[i][11]);
            check($sformatf("R%0d vec%0d", VEC[i][39:36], i),
                  VEC[i][10:6], VEC[i][5:1], VEC[i][0]);
        end

        // R4: one return walking decode -> writeback holds fetch 3 cycles
        fetch_holds = 0;
        drive(4'h9, 4'h2, 4'h1, 4'h4, 4'hF, 4'hF, 1'b0);
        fetch_holds += int'(stall[0]);
        drive(4'h1, 4'h9, 4'h2, 4'hF, 4'hF, 4'hF, 1'b0);
        fetch_holds += int'(stall[0]);
        drive(4'h1, 4'h1, 4'h9, 4'hF, 4'hF, 4'hF, 1'b0);
        fetch_holds += int'(stall[0]);
        drive(4'h2, 4'h1, 4'h1, 4'h1, 4'h2, 4'hF, 1'b0);
        fetch_holds += int'(stall[0]);
        checks++;
        if (fetch_holds != 3) begin
            errors++;
            $display("FAIL R4: fetch holds=%0d expected 3", fetch_holds);
        end

        // R3: match only through 0xF on srcB, real source differs
        drive(4'h2, 4'h5, 4'h1, 4'h2, 4'hF, 4'hF, 1'b0);
        check("R3 none-id", 5'b0, 5'b0, 1'b0);

        // R8: load/use with return in execute is impossible; return in decode via srcB
        drive(4'h9, 4'hB, 4'h1, 4'hF, 4'h4, 4'h4, 1'b0);
        check("R8 ret srcB", 5'b00011, 5'b00100, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule